// File: doc/BRIEF.md
# Pipeline Hazard Interlock

This block is the stall and operand-steering controller for an in-order RISC pipeline with five stages: fetch, decode, execute, memory and write-back. The decode stage supplies the register fields of the instruction waiting there: two source indices with use flags, a destination index, a write flag, and load and branch flags. The block keeps its own copy of these fields for the instructions in execute, memory and write-back. From them it decides whether the decode instruction may advance. While it asserts `stall`, the program counter and the fetch/decode register must hold, and the block puts a bubble (write flag zero) into execute. Branches resolve in decode and never flush the instruction behind them. Likewise, the instruction after a load sits in a delay slot and is not cancelled.

The parameter `BYPASS` selects one of two modes. With `BYPASS=0` nothing is forwarded, so a consumer waits until its producer has reached write-back. The register file writes in the first half of a cycle and reads in the second, so the consumer can read the value in that same cycle. With `BYPASS=1` the block drives select codes that steer ALU results from the memory or write-back stage into the execute operands. Only a use directly behind a load, and a branch whose condition source is still being produced, cost extra cycles.

Top module: `hzd_interlock`

## Requirements
- R1: After reset, all tracked stages hold bubbles: `stall`=0, `wb_we`=0, `fwd_a_sel`=`fwd_b_sel`=0 and `br_fwd`=0.
- R2: With BYPASS=0, a used decode source that equals the destination of a writing instruction in execute or memory stalls decode. A producer already in write-back causes no stall, so an ALU or load consumer directly behind its producer waits 2 cycles.
- R3: Register index 0 and instructions whose write flag is 0 never cause a stall and never select a forwarded operand.
- R4: Each stalled cycle sends a bubble into execute. The held instruction enters execute once `stall` drops and reaches `wb_we`/`wb_rd` two cycles later.
- R5: With BYPASS=1, a non-branch consumer stalls exactly 1 cycle when it directly follows a load that writes one of its used sources. It never stalls behind an ALU producer.
- R6: With BYPASS=1, a branch stalls while the writer of its first source is in execute. It also stalls while a load writing that source is in memory. An ALU producer costs 1 cycle and a load producer costs 2.
- R7: Forward codes for each execute operand: 0 = register file, 1 = from the memory-stage result, 2 = from the write-back-stage result. When both stages write the source, code 1 wins.
- R8: With BYPASS=1, `br_fwd`=1 while a decoded branch takes its first source from a non-load producer in the memory stage.
- R9: A source whose use flag is 0 never causes a stall, even when its index matches a pending destination.
- R10: The instruction after a branch, and an independent instruction after a load, advance with no stall and retire through write-back; nothing is flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_rs1 | input | 5 | First source index (branch condition source) |
| id_use1 | input | 1 | First source is read |
| id_rs2 | input | 5 | Second source index |
| id_use2 | input | 1 | Second source is read |
| id_rd | input | 5 | Destination index |
| id_we | input | 1 | Instruction writes its destination |
| id_load | input | 1 | Instruction is a load |
| id_branch | input | 1 | Instruction is a conditional branch |
| stall | output | 1 | Hold PC and fetch/decode register, bubble into execute |
| fwd_a_sel | output | 2 | Forward code for execute operand A |
| fwd_b_sel | output | 2 | Forward code for execute operand B |
| br_fwd | output | 1 | Branch compare takes memory-stage result |
| wb_we | output | 1 | Write flag of the instruction in write-back |
| wb_rd | output | 5 | Destination of the instruction in write-back |

## Verification
A wrong stage copy inside the block shows at the ports in one of two ways. Either `stall` has the wrong length in the cycle a dependent instruction sits in decode, or the forward codes are wrong in the very next cycle. A bubble that is missing or duplicated shows up two cycles later as the wrong `wb_we`/`wb_rd`. The tests therefore measure stall counts per dependence distance and producer kind. They sample the forward codes one cycle after acceptance, and they follow each key instruction out through write-back.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int unsigned REG_AW = 5;
  typedef logic [REG_AW-1:0] ridx_t;

  // Control view of one pipeline slot
  typedef struct packed {
    logic  we;
    logic  load;
    ridx_t rd;
    logic  use1;
    ridx_t rs1;
    logic  use2;
    ridx_t rs2;
  } sctl_t;

  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_e;

  localparam sctl_t BUBBLE = '0;

  // A used, nonzero source matches a writing producer
  function automatic logic src_hit(ridx_t src, logic used, sctl_t prod);
    return used && (src != '0) && prod.we && (prod.rd == src);
  endfunction

  function automatic logic any_hit(sctl_t cons, sctl_t prod);
    return src_hit(cons.rs1, cons.use1, prod) || src_hit(cons.rs2, cons.use2, prod);
  endfunction
endpackage

// File: rtl/hzd_stage_pipe.sv
module hzd_stage_pipe
  import hzd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stall,
  input  sctl_t id_ctl,
  output sctl_t ex_ctl,
  output sctl_t mem_ctl,
  output sctl_t wb_ctl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_ctl  <= BUBBLE;
      mem_ctl <= BUBBLE;
      wb_ctl  <= BUBBLE;
    end else begin
      ex_ctl  <= stall ? BUBBLE : id_ctl;
      mem_ctl <= ex_ctl;
      wb_ctl  <= mem_ctl;
    end
  end
endmodule

// File: rtl/hzd_stall_detect.sv
module hzd_stall_detect
  import hzd_pkg::*;
#(
  parameter bit BYPASS = 1'b0
) (
  input  logic  id_branch,
  input  sctl_t id_ctl,
  input  sctl_t ex_ctl,
  input  sctl_t mem_ctl,
  output logic  stall,
  output logic  br_fwd
);
  // Named hazard events, visible to the checker and to waveforms
  logic hit_ex, hit_mem, br_hit_ex, br_hit_mem;
  assign hit_ex     = any_hit(id_ctl, ex_ctl);
  assign hit_mem    = any_hit(id_ctl, mem_ctl);
  assign br_hit_ex  = id_branch && src_hit(id_ctl.rs1, id_ctl.use1, ex_ctl);
  assign br_hit_mem = id_branch && src_hit(id_ctl.rs1, id_ctl.use1, mem_ctl);

  generate
    if (BYPASS) begin : g_bypass
      assign stall  = (hit_ex && ex_ctl.load) || br_hit_ex || (br_hit_mem && mem_ctl.load);
      assign br_fwd = br_hit_mem && !mem_ctl.load;
    end else begin : g_plain
      // Producer must reach write-back; split-cycle register file covers it
      assign stall  = hit_ex || hit_mem;
      assign br_fwd = 1'b0;
    end
  endgenerate

  logic unused_bits;
  assign unused_bits = ^{id_ctl.we, id_ctl.load, id_ctl.rd, ex_ctl.rs1, ex_ctl.rs2,
                         ex_ctl.use1, ex_ctl.use2, mem_ctl.rs1, mem_ctl.rs2,
                         mem_ctl.use1, mem_ctl.use2};
endmodule

// File: rtl/hzd_fwd_select.sv
module hzd_fwd_select
  import hzd_pkg::*;
#(
  parameter bit BYPASS = 1'b0
) (
  input  sctl_t ex_ctl,
  input  sctl_t mem_ctl,
  input  sctl_t wb_ctl,
  output fwd_e  fwd_a,
  output fwd_e  fwd_b
);
  function automatic fwd_e pick(ridx_t src, logic used, sctl_t m, sctl_t w);
    if (src_hit(src, used, m))      return FWD_MEM;
    else if (src_hit(src, used, w)) return FWD_WB;
    else                            return FWD_RF;
  endfunction

  generate
    if (BYPASS) begin : g_bypass
      assign fwd_a = pick(ex_ctl.rs1, ex_ctl.use1, mem_ctl, wb_ctl);
      assign fwd_b = pick(ex_ctl.rs2, ex_ctl.use2, mem_ctl, wb_ctl);
    end else begin : g_plain
      assign fwd_a = FWD_RF;
      assign fwd_b = FWD_RF;
    end
  endgenerate

  logic unused_bits;
  assign unused_bits = ^{ex_ctl, mem_ctl, wb_ctl};
endmodule

// File: rtl/hzd_interlock.sv
module hzd_interlock
  import hzd_pkg::*;
#(
  parameter bit BYPASS = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        id_valid,
  input  logic [4:0]  id_rs1,
  input  logic        id_use1,
  input  logic [4:0]  id_rs2,
  input  logic        id_use2,
  input  logic [4:0]  id_rd,
  input  logic        id_we,
  input  logic        id_load,
  input  logic        id_branch,
  output logic        stall,
  output logic [1:0]  fwd_a_sel,
  output logic [1:0]  fwd_b_sel,
  output logic        br_fwd,
  output logic        wb_we,
  output logic [4:0]  wb_rd
);
  sctl_t id_ctl, ex_ctl, mem_ctl, wb_ctl;
  fwd_e  fwd_a, fwd_b;
  logic  id_br_live;

  // An empty decode slot behaves like a bubble
  always_comb begin
    id_ctl      = BUBBLE;
    id_ctl.we   = id_valid && id_we;
    id_ctl.load = id_valid && id_load;
    id_ctl.rd   = id_rd;
    id_ctl.use1 = id_valid && id_use1;
    id_ctl.rs1  = id_rs1;
    id_ctl.use2 = id_valid && id_use2;
    id_ctl.rs2  = id_rs2;
  end
  assign id_br_live = id_valid && id_branch;

  hzd_stall_detect #(.BYPASS(BYPASS)) u_detect (
    .id_branch (id_br_live),
    .id_ctl    (id_ctl),
    .ex_ctl    (ex_ctl),
    .mem_ctl   (mem_ctl),
    .stall     (stall),
    .br_fwd    (br_fwd)
  );

  hzd_stage_pipe u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall   (stall),
    .id_ctl  (id_ctl),
    .ex_ctl  (ex_ctl),
    .mem_ctl (mem_ctl),
    .wb_ctl  (wb_ctl)
  );

  hzd_fwd_select #(.BYPASS(BYPASS)) u_fwd (
    .ex_ctl  (ex_ctl),
    .mem_ctl (mem_ctl),
    .wb_ctl  (wb_ctl),
    .fwd_a   (fwd_a),
    .fwd_b   (fwd_b)
  );

  assign fwd_a_sel = fwd_a;
  assign fwd_b_sel = fwd_b;
  assign wb_we     = wb_ctl.we;
  assign wb_rd     = wb_ctl.rd;

  logic unused_bits;
  assign unused_bits = ^{wb_ctl.load, wb_ctl.rs1, wb_ctl.rs2, wb_ctl.use1, wb_ctl.use2};
endmodule

// File: rtl/hzd_interlock_chk.sv
module hzd_interlock_chk
  import hzd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       stall,
  input logic       id_valid,
  input logic       id_branch,
  input logic [4:0] id_rs1,
  input logic       id_use1,
  input logic       id_we,
  input logic [1:0] fwd_a_sel,
  input logic [1:0] fwd_b_sel,
  input logic       br_fwd,
  input sctl_t      ex_ctl,
  input sctl_t      mem_ctl
);
  p_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_ctl.we);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && id_valid && id_we) |=> ex_ctl.we);

  p_br_ex_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_branch && id_use1 && id_rs1 != '0 && ex_ctl.we && ex_ctl.rd == id_rs1)
      |-> stall);

  p_zero_fwd_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_sel != 2'd0) |-> (ex_ctl.rs1 != '0));

  p_zero_fwd_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_b_sel != 2'd0) |-> (ex_ctl.rs2 != '0));

  p_no_load_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_sel == 2'd1 || fwd_b_sel == 2'd1) |-> !mem_ctl.load);

  p_brfwd_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    br_fwd |-> (mem_ctl.we && !mem_ctl.load));

  p_fwd_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_sel != 2'd3) && (fwd_b_sel != 2'd3));
endmodule

bind hzd_interlock hzd_interlock_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stall     (stall),
  .id_valid  (id_valid),
  .id_branch (id_branch),
  .id_rs1    (id_rs1),
  .id_use1   (id_use1),
  .id_we     (id_we),
  .fwd_a_sel (fwd_a_sel),
  .fwd_b_sel (fwd_b_sel),
  .br_fwd    (br_fwd),
  .ex_ctl    (ex_ctl),
  .mem_ctl   (mem_ctl)
);

// File: tb/hzd_interlock_test.sv
module hzd_interlock_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       id_valid, id_use1, id_use2, id_we, id_load, id_branch;
  logic [4:0] id_rs1, id_rs2, id_rd;

  logic       st_p, bf_p, we_p;  logic [1:0] fa_p, fb_p;  logic [4:0] rd_p;
  logic       st_b, bf_b, we_b;  logic [1:0] fa_b, fb_b;  logic [4:0] rd_b;

  hzd_interlock #(.BYPASS(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_rs1(id_rs1), .id_use1(id_use1),
    .id_rs2(id_rs2), .id_use2(id_use2), .id_rd(id_rd), .id_we(id_we), .id_load(id_load),
    .id_branch(id_branch), .stall(st_p), .fwd_a_sel(fa_p), .fwd_b_sel(fb_p),
    .br_fwd(bf_p), .wb_we(we_p), .wb_rd(rd_p));

  hzd_interlock #(.BYPASS(1'b1)) uut_byp (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_rs1(id_rs1), .id_use1(id_use1),
    .id_rs2(id_rs2), .id_use2(id_use2), .id_rd(id_rd), .id_we(id_we), .id_load(id_load),
    .id_branch(id_branch), .stall(st_b), .fwd_a_sel(fa_b), .fwd_b_sel(fb_b),
    .br_fwd(bf_b), .wb_we(we_b), .wb_rd(rd_b));

  int n_chk = 0, n_bad = 0;
  bit mode = 1'b0;   // 0: plain instance, 1: bypass instance

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(int rs1, bit u1, int rs2, bit u2, int rd, bit we, bit ld, bit br, bit v);
    id_valid = v; id_rs1 = 5'(rs1); id_use1 = u1; id_rs2 = 5'(rs2); id_use2 = u2;
    id_rd = 5'(rd); id_we = we; id_load = ld; id_branch = br;
  endtask

  task automatic do_reset();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Present one instruction at a negedge, count stalled cycles until accepted.
  // Returns at the negedge after acceptance (instruction now in execute).
  task automatic issue(int rs1, bit u1, int rs2, bit u2, int rd, bit we, bit ld, bit br,
                       output int stalls, output bit bfwd);
    drive(rs1, u1, rs2, u2, rd, we, ld, br, 1);
    stalls = 0;
    forever begin
      #1;
      bfwd = mode ? bf_b : bf_p;
      if (!(mode ? st_b : st_p)) break;
      stalls++;
      @(negedge clk);
      if (stalls > 8) break;
    end
    @(posedge clk);
    #1 drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
  endtask

  task automatic nop(); int s; bit b; issue(0, 0, 0, 0, 0, 0, 0, 0, s, b); endtask
  task automatic alu(int rd, int a, bit ua, int b, bit ub, output int s);
    bit f; issue(a, ua, b, ub, rd, 1, 0, 0, s, f);
  endtask

  task automatic t_reset();
    do_reset(); #1;
    check("R1 stall plain", st_p, 0);   check("R1 stall byp", st_b, 0);
    check("R1 wb_we", we_p | we_b, 0);  check("R1 fwd", fa_b | fb_b, 0);
    check("R1 br_fwd", bf_b, 0);
  endtask

  task automatic t_plain_chain();
    int s;
    mode = 0; do_reset();
    alu(3, 1, 1, 2, 1, s);
    alu(5, 3, 1, 0, 0, s);
    check("R2 alu-use stalls", s, 2);
    check("R4 bubble in wb", we_p, 0);
    nop(); nop();
    check("R4 held insn retires we", we_p, 1);
    check("R4 held insn retires rd", rd_p, 5);
    do_reset();
    begin bit f; issue(1, 1, 0, 0, 6, 1, 1, 0, s, f); end
    alu(7, 0, 0, 6, 1, s);
    check("R2 load-use stalls", s, 2);
  endtask

  task automatic t_plain_wb();
    int s;
    mode = 0; do_reset();
    alu(3, 1, 1, 0, 0, s);
    alu(6, 0, 0, 0, 0, s);
    alu(7, 0, 0, 0, 0, s);
    alu(8, 0, 0, 3, 1, s);
    check("R2 producer in wb no stall", s, 0);
    do_reset();
    alu(3, 1, 1, 0, 0, s);
    alu(9, 0, 0, 0, 0, s);
    alu(8, 3, 1, 0, 0, s);
    check("R2 producer in mem stalls", s, 1);
  endtask

  task automatic t_zero_unused(bit m);
    int s; bit f;
    mode = m; do_reset();
    alu(0, 1, 1, 0, 0, s);
    alu(4, 0, 1, 0, 1, s);
    check("R3 r0 no stall", s, 0);
    check("R3 r0 no fwd", m ? int'(fa_b) : 0, 0);
    issue(1, 1, 3, 1, 3, 0, 0, 0, s, f);   // store-like: writes nothing
    alu(4, 3, 1, 0, 0, s);
    check("R3 we0 no stall", s, 0);
    check("R3 we0 no fwd", m ? int'(fa_b) : 0, 0);
    do_reset();
    issue(1, 1, 0, 0, 4, 1, 1, 0, s, f);   // load r4
    alu(5, 2, 1, 4, 0, s);
    check("R9 unused src no stall", s, 0);
  endtask

  task automatic t_byp_fwd();
    int s; bit f;
    mode = 1; do_reset();
    alu(3, 1, 1, 0, 0, s);
    alu(5, 3, 1, 3, 1, s);
    check("R5 alu-use no stall", s, 0);
    check("R7 fwd_a mem", fa_b, 1);
    check("R7 fwd_b mem", fb_b, 1);
    alu(8, 0, 0, 0, 0, s);
    alu(6, 0, 0, 0, 0, s);
    alu(10, 1, 1, 8, 1, s);
    check("R7 fwd_b wb", fb_b, 2);
    check("R7 fwd_a rf", fa_b, 0);
    alu(9, 0, 0, 0, 0, s);
    alu(9, 0, 0, 0, 0, s);
    alu(11, 9, 1, 0, 0, s);
    check("R7 mem over wb", fa_b, 1);
    do_reset();
    issue(1, 1, 0, 0, 3, 1, 1, 0, s, f);
    alu(5, 3, 1, 0, 0, s);
    check("R5 load-use stalls", s, 1);
    check("R7 load via wb", fa_b, 2);
  endtask

  task automatic t_branch();
    int s; bit f;
    mode = 1; do_reset();
    alu(4, 0, 0, 0, 0, s);
    issue(4, 1, 0, 0, 0, 0, 0, 1, s, f);
    check("R6 alu-branch stalls", s, 1);
    check("R8 br_fwd", f, 1);
    do_reset();
    issue(1, 1, 0, 0, 4, 1, 1, 0, s, f);
    issue(4, 1, 0, 0, 0, 0, 0, 1, s, f);
    check("R6 load-branch stalls", s, 2);
    check("R8 no br_fwd after load", f, 0);
    mode = 0; do_reset();
    alu(4, 0, 0, 0, 0, s);
    issue(4, 1, 0, 0, 0, 0, 0, 1, s, f);
    check("R2 plain branch stalls", s, 2);
  endtask

  task automatic t_delay_slots();
    int s; bit f;
    mode = 1; do_reset();
    issue(0, 1, 0, 0, 0, 0, 0, 1, s, f);
    alu(7, 1, 1, 2, 1, s);
    check("R10 branch slot no stall", s, 0);
    nop(); nop();
    check("R10 slot retires we", we_b, 1);
    check("R10 slot retires rd", rd_b, 7);
    do_reset();
    issue(1, 1, 0, 0, 3, 1, 1, 0, s, f);
    alu(12, 5, 1, 6, 1, s);
    check("R10 load slot independent", s, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_plain_chain();
    t_plain_wb();
    t_zero_unused(1'b0);
    t_zero_unused(1'b1);
    t_byp_fwd();
    t_branch();
    t_delay_slots();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule